// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This peripheral holds a small array of independent 64-bit countdown channels behind a plain synchronous register port. Software loads each channel's interval as two 32-bit halves. It then writes the channel's control word with both the run bit and the load strobe set. The load copies the interval into the live counter, and the counter steps down once per prescaled tick. When a tick arrives while the counter already reads zero, the channel expires. A repeating channel refills from its interval and keeps going. A single-shot channel stops at zero, drops its own run bit and waits for software.

Each expiry latches a pending flag in a shared status word. Software clears a flag by writing a one to its bit. A shared mask word selects which pending flags drive the single interrupt line. Stopping a channel is not instant: the counter keeps stepping for a fixed number of clock cycles after the stop write, as if the request had to cross into a separate counting clock. Software that needs a quiet counter waits out that window before it reprograms the channel.

Top module: `multi_down_timer`

## Requirements
- R1: After reset, the mask word, the status word and every channel's control, interval and count words read zero, and `irq` is low.
- R2: A control write with bit 0 (run) and bit 1 (load) both set copies the interval into the counter on that clock edge. At prescale 0, the counter then drops by one on every later edge.
- R3: Control bits 6:4 hold a prescale select p. The counter steps once every 2^p clock cycles, and the first step after a load comes 2^p edges after the load edge.
- R4: In repeating mode (control bit 7 clear), a tick that finds the counter at zero reloads the interval and sets the channel's status bit. An interval of I therefore gives one expiry every I+1 ticks.
- R5: In single-shot mode (control bit 7 set), expiry sets the status bit, clears the run bit (control then reads 0x80 with prescale 0) and leaves the counter at zero with no further expiries.
- R6: `irq` is high exactly when some channel has both its status bit (offset 0x04, bit n) and its mask bit (offset 0x00, bit n) set. Expiry sets the status bit whatever the mask holds.
- R7: Writing status bits with one clears them and writing zero leaves them alone. If an expiry and a clear land on the same edge, the bit stays set.
- R8: After a control write that clears run on a counting channel, the counter advances on exactly SYNC_DLY (default 2) further edges and then holds.
- R9: Channel n's control word is at 0x20*n+0x10, its interval at +0x14 (low) and +0x18 (high), and its count at +0x1C (low) and +0x20 (high). A decrement borrows from the high word into the low word.
- R10: Count words ignore writes, control bit 1 reads back as zero, and any offset outside the map reads zero.
- R11: Channels count independently, each with its own prescale, mode and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR over channels of pending AND mask |

## Verification
A bad prescaler phase or a skipped load appears in the count words within 2^p cycles of the start write. A slipped expiry condition moves the status bit and `irq` by a whole tick in the cycle-exact sequences. A wrong drain length after a stop write appears as a count that is off by one, read a few cycles later. A single-shot channel that keeps its run bit shows up in the control readback right after expiry, and a second expiry shows up once the status bit has been cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int PRE_W      = 3;
   // shared register offsets
   localparam int ADR_MASK   = 'h00;
   localparam int ADR_PEND   = 'h04;
   localparam int WIN_BASE   = 'h10;
   localparam int WIN_SHIFT  = 5;
   // offsets inside a channel window
   localparam logic [4:0] SUB_CTRL   = 5'h00;
   localparam logic [4:0] SUB_IVL_LO = 5'h04;
   localparam logic [4:0] SUB_IVL_HI = 5'h08;
   localparam logic [4:0] SUB_CNT_LO = 5'h0C;
   localparam logic [4:0] SUB_CNT_HI = 5'h10;
   // control word bit positions
   localparam int CB_RUN     = 0;
   localparam int CB_LOAD    = 1;
   localparam int CB_PRE     = 4;
   localparam int CB_SINGLE  = 7;

   typedef struct packed {
      logic             single;
      logic [PRE_W-1:0] pre;
      logic             run;
   } chan_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int CW = (1 << SEL_W) - 1;

   logic [CW-1:0] phase_q;
   logic [CW-1:0] limit;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("tmr_prescaler: SEL_W out of range");
   end

   always_comb limit = (CW'(1) << sel) - CW'(1);
   assign tick = run && (phase_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (clr)     phase_q <= '0;
      else if (run)     phase_q <= tick ? '0 : phase_q + CW'(1);
   end

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel != '0 && !clr) |=> (!tick || sel == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SYNC_DLY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_ivl_lo,
   input  logic              wr_ivl_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [2*DATA_W-1:0] ivl_o,
   output logic [2*DATA_W-1:0] cnt_o,
   output logic              expire_o
);
   localparam int CNT_W = 2 * DATA_W;
   localparam int DW    = $clog2(SYNC_DLY + 1);

   chan_ctrl_t        ctl_q;
   logic [CNT_W-1:0]  ivl_q, cnt_q;
   logic              running_q;
   logic [DW-1:0]     drain_q;
   logic              tick, start, resume, stop_req, expire;

   if (SYNC_DLY < 1) begin : g_bad_dly
      $error("tmr_channel: SYNC_DLY must be at least 1");
   end

   assign start    = wr_ctrl && wdata[CB_RUN] && wdata[CB_LOAD];
   assign resume   = wr_ctrl && wdata[CB_RUN] && !wdata[CB_LOAD];
   assign stop_req = wr_ctrl && !wdata[CB_RUN] && running_q;
   assign expire   = tick && (cnt_q == '0);

   tmr_prescaler #(.SEL_W(PRE_W)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .run   (running_q),
      .sel   (ctl_q.pre),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         ivl_q <= '0;
      end else begin
         if (expire && ctl_q.single) ctl_q.run <= 1'b0;
         if (wr_ctrl) begin
            ctl_q.run    <= wdata[CB_RUN];
            ctl_q.pre    <= wdata[CB_PRE +: PRE_W];
            ctl_q.single <= wdata[CB_SINGLE];
         end
         if (wr_ivl_lo) ivl_q[DATA_W-1:0]     <= wdata;
         if (wr_ivl_hi) ivl_q[CNT_W-1:DATA_W] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (start)   cnt_q <= ivl_q;
      else if (tick) begin
         if (cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
         else if (!ctl_q.single) cnt_q <= ivl_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         drain_q   <= '0;
      end else if (start || resume) begin
         running_q <= 1'b1;
         drain_q   <= '0;
      end else if (expire && ctl_q.single) begin
         running_q <= 1'b0;
         drain_q   <= '0;
      end else if (stop_req) begin
         drain_q   <= DW'(SYNC_DLY);
      end else if (drain_q != '0) begin
         drain_q   <= drain_q - DW'(1);
         if (drain_q == DW'(1)) running_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_rd                       = '0;
      ctrl_rd[CB_RUN]               = ctl_q.run;
      ctrl_rd[CB_PRE +: PRE_W]      = ctl_q.pre;
      ctrl_rd[CB_SINGLE]            = ctl_q.single;
   end

   assign ivl_o    = ivl_q;
   assign cnt_o    = cnt_q;
   assign expire_o = expire;

   // R2
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == $past(ivl_q)));
   // R5
   single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctl_q.single && !wr_ctrl) |=> (!ctl_q.run && !running_q && cnt_q == '0));
   // R8
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && !wr_ctrl) |=> $stable(cnt_q));
   // R8
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !expire) |=> running_q);

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
   parameter int N_CH = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_mask,
   input  logic            wr_pend,
   input  logic [N_CH-1:0] wbits,
   input  logic [N_CH-1:0] expire,
   output logic [N_CH-1:0] mask_o,
   output logic [N_CH-1:0] pend_o,
   output logic            irq
);
   logic [N_CH-1:0] mask_q, pend_q, clr;

   assign clr = wr_pend ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         pend_q <= '0;
      end else begin
         if (wr_mask) mask_q <= wbits;
         pend_q <= (pend_q & ~clr) | expire;
      end
   end

   assign mask_o = mask_q;
   assign pend_o = pend_q;
   assign irq    = |(mask_q & pend_q);

   for (genvar c = 0; c < N_CH; c++) begin : g_chk
      // R7
      set_on_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
         expire[c] |=> pend_q[c]);
      // R7
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_pend && wbits[c] && !expire[c]) |=> !pend_q[c]);
   end

   // R6
   quiet_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

endmodule

// File: rtl/multi_down_timer.sv
module multi_down_timer
   import tmr_pkg::*;
#(
   parameter int N_CH     = 2,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int SYNC_DLY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int CH_W  = ADDR_W - WIN_SHIFT;
   localparam int CNT_W = 2 * DATA_W;

   if (N_CH < 1 || N_CH > DATA_W) begin : g_bad_nch
      $error("multi_down_timer: N_CH out of range");
   end
   if (WIN_BASE + (N_CH << WIN_SHIFT) > (1 << ADDR_W)) begin : g_bad_addr
      $error("multi_down_timer: ADDR_W too small for N_CH");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("multi_down_timer: DATA_W too small for control word");
   end

   logic [ADDR_W-1:0]   rel;
   logic [CH_W-1:0]     ch_idx;
   logic [4:0]          sub;
   logic                in_win;

   logic [N_CH-1:0]     wr_ctrl, wr_lo, wr_hi, expire, mask, pend;
   logic [DATA_W-1:0]   ctrl_rd [N_CH];
   logic [CNT_W-1:0]    ivl     [N_CH];
   logic [CNT_W-1:0]    cnt     [N_CH];

   assign rel    = bus_addr - ADDR_W'(WIN_BASE);
   assign ch_idx = rel[ADDR_W-1:WIN_SHIFT];
   assign sub    = rel[WIN_SHIFT-1:0];
   assign in_win = (bus_addr >= ADDR_W'(WIN_BASE)) && (ch_idx < CH_W'(N_CH));

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic hit;
      assign hit        = bus_wr && in_win && (ch_idx == CH_W'(c));
      assign wr_ctrl[c] = hit && (sub == SUB_CTRL);
      assign wr_lo[c]   = hit && (sub == SUB_IVL_LO);
      assign wr_hi[c]   = hit && (sub == SUB_IVL_HI);

      tmr_channel #(.DATA_W(DATA_W), .SYNC_DLY(SYNC_DLY)) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_ctrl   (wr_ctrl[c]),
         .wr_ivl_lo (wr_lo[c]),
         .wr_ivl_hi (wr_hi[c]),
         .wdata     (bus_wdata),
         .ctrl_rd   (ctrl_rd[c]),
         .ivl_o     (ivl[c]),
         .cnt_o     (cnt[c]),
         .expire_o  (expire[c])
      );
   end

   tmr_irq_ctrl #(.N_CH(N_CH)) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mask (bus_wr && bus_addr == ADDR_W'(ADR_MASK)),
      .wr_pend (bus_wr && bus_addr == ADDR_W'(ADR_PEND)),
      .wbits   (bus_wdata[N_CH-1:0]),
      .expire  (expire),
      .mask_o  (mask),
      .pend_o  (pend),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_MASK))      bus_rdata = DATA_W'(mask);
      else if (bus_addr == ADDR_W'(ADR_PEND)) bus_rdata = DATA_W'(pend);
      else if (in_win) begin
         for (int c = 0; c < N_CH; c++) begin
            if (ch_idx == CH_W'(c)) begin
               case (sub)
                  SUB_CTRL:   bus_rdata = ctrl_rd[c];
                  SUB_IVL_LO: bus_rdata = ivl[c][DATA_W-1:0];
                  SUB_IVL_HI: bus_rdata = ivl[c][CNT_W-1:DATA_W];
                  SUB_CNT_LO: bus_rdata = cnt[c][DATA_W-1:0];
                  SUB_CNT_HI: bus_rdata = cnt[c][CNT_W-1:DATA_W];
                  default:    bus_rdata = '0;
               endcase
            end
         end
      end
   end

   // R6
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ((mask & pend) != '0));

endmodule

// File: tb/test_multi_down_timer.sv
`timescale 1ns/1ps
module test_multi_down_timer;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   multi_down_timer #(.N_CH(2), .ADDR_W(AW), .DATA_W(DW), .SYNC_DLY(2)) i_multi_down_timer (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
   );

   function automatic logic [AW-1:0] a_ctl(int n);  return AW'(32*n + 'h10); endfunction
   function automatic logic [AW-1:0] a_ilo(int n);  return AW'(32*n + 'h14); endfunction
   function automatic logic [AW-1:0] a_ihi(int n);  return AW'(32*n + 'h18); endfunction
   function automatic logic [AW-1:0] a_clo(int n);  return AW'(32*n + 'h1C); endfunction
   function automatic logic [AW-1:0] a_chi(int n);  return AW'(32*n + 'h20); endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bus_wr = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic rd_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
      bus_addr = a;
      #0.01;
      check(tag, 64'(bus_rdata), 64'(exp));
   endtask

   task automatic t_reset();
      do_reset();
      rd_chk("R1 mask", 8'h00, 0);
      rd_chk("R1 pend", 8'h04, 0);
      rd_chk("R1 ctrl", a_ctl(1), 0);
      rd_chk("R1 ivl", a_ilo(0), 0);
      rd_chk("R1 cnt", a_clo(0), 0);
      check("R1 irq", 64'(irq), 0);
   endtask

   task automatic t_load();
      do_reset();
      wr(a_ilo(0), 100);
      wr(a_ctl(0), 32'h3);
      rd_chk("R2 loaded", a_clo(0), 100);
      idle(5);
      rd_chk("R2 counted", a_clo(0), 95);
      rd_chk("R2 hi", a_chi(0), 0);
   endtask

   task automatic t_prescale();
      do_reset();
      wr(a_ilo(1), 50);
      wr(a_ctl(1), 32'h23);
      idle(3);
      rd_chk("R3 before first tick", a_clo(1), 50);
      idle(1);
      rd_chk("R3 first tick", a_clo(1), 49);
      idle(8);
      rd_chk("R3 rate", a_clo(1), 47);
   endtask

   task automatic t_periodic();
      do_reset();
      wr(a_ilo(0), 4);
      wr(a_ctl(0), 32'h3);
      idle(4);
      rd_chk("R4 at zero", a_clo(0), 0);
      rd_chk("R4 no pend yet", 8'h04, 0);
      idle(1);
      rd_chk("R4 reload", a_clo(0), 4);
      rd_chk("R4 pend set", 8'h04, 1);
      check("R6 masked irq", 64'(irq), 0);
      wr(8'h00, 1);
      check("R6 irq on", 64'(irq), 1);
      wr(8'h04, 0);
      rd_chk("R7 zero write", 8'h04, 1);
      wr(8'h04, 1);
      rd_chk("R7 cleared", 8'h04, 0);
      check("R7 irq off", 64'(irq), 0);
      rd_chk("R4 running", a_clo(0), 1);
      idle(2);
      rd_chk("R4 second expiry", 8'h04, 1);
      check("R6 irq again", 64'(irq), 1);
   endtask

   task automatic t_single();
      do_reset();
      wr(a_ilo(0), 3);
      wr(a_ctl(0), 32'h83);
      idle(3);
      rd_chk("R5 pre expiry", 8'h04, 0);
      idle(1);
      rd_chk("R5 pend", 8'h04, 1);
      rd_chk("R5 run cleared", a_ctl(0), 32'h80);
      rd_chk("R5 held", a_clo(0), 0);
      wr(8'h04, 1);
      idle(10);
      rd_chk("R5 no rerun", 8'h04, 0);
      rd_chk("R5 still zero", a_clo(0), 0);
   endtask

   task automatic t_drain();
      do_reset();
      wr(a_ilo(0), 1000);
      wr(a_ctl(0), 32'h3);
      idle(10);
      rd_chk("R8 counting", a_clo(0), 990);
      wr(a_ctl(0), 32'h0);
      rd_chk("R8 stop edge", a_clo(0), 989);
      idle(5);
      rd_chk("R8 drained", a_clo(0), 987);
      rd_chk("R8 ctrl", a_ctl(0), 0);
   endtask

   task automatic t_borrow();
      do_reset();
      wr(a_ilo(0), 0);
      wr(a_ihi(0), 1);
      rd_chk("R9 ivl hi", a_ihi(0), 1);
      wr(a_ctl(0), 32'h3);
      rd_chk("R9 cnt hi", a_chi(0), 1);
      idle(1);
      rd_chk("R9 borrow lo", a_clo(0), 32'hFFFF_FFFF);
      rd_chk("R9 borrow hi", a_chi(0), 0);
   endtask

   task automatic t_readonly();
      do_reset();
      wr(a_ilo(0), 20);
      wr(a_ctl(0), 32'h3);
      rd_chk("R10 load bit reads 0", a_ctl(0), 1);
      wr(a_clo(0), 7);
      rd_chk("R10 cnt lo ignores write", a_clo(0), 19);
      wr(a_chi(0), 5);
      rd_chk("R10 cnt hi ignores write", a_chi(0), 0);
      rd_chk("R10 lo after", a_clo(0), 18);
      rd_chk("R10 hole in window", 8'h24, 0);
      rd_chk("R10 hole shared", 8'h08, 0);
      rd_chk("R10 beyond map", 8'h70, 0);
   endtask

   task automatic t_indep();
      do_reset();
      wr(8'h00, 2);
      wr(a_ilo(0), 10);
      wr(a_ilo(1), 10);
      wr(a_ctl(0), 32'h3);
      wr(a_ctl(1), 32'h13);
      rd_chk("R11 ch0", a_clo(0), 9);
      rd_chk("R11 ch1", a_clo(1), 10);
      idle(4);
      rd_chk("R11 ch0 later", a_clo(0), 5);
      rd_chk("R11 ch1 later", a_clo(1), 8);
      idle(6);
      rd_chk("R11 ch0 expired only", 8'h04, 1);
      check("R6 unmasked chan no irq", 64'(irq), 0);
      rd_chk("R11 ch1 at E11", a_clo(1), 5);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_load();
      t_prescale();
      t_periodic();
      t_single();
      t_drain();
      t_borrow();
      t_readonly();
      t_indep();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule